// File: doc/BRIEF.md
# Burst Capture Buffer with Serial Drain

This block sits between a sampling converter and a slow transmit-only serial link. A sequencer asks the converter for one result at a time and stores every result in an on-chip first-in first-out store. The store holds 128 words of 16 bits by default, and one clock serves both sides. Capture and transmission are interlocked through the store's full flag. While the store has room, requests keep coming. When it fills, requests pause and draining begins. Every read that frees a slot lets the next request go out.

Draining sends each stored word as one asynchronous serial frame. The line idles high. A frame is a low start bit, the sixteen data bits least significant first, and a high stop bit. Each bit lasts eight ticks of an oversampling tick. That tick is divided down from the system clock, and the default gives 9600 baud from 50 MHz. Draining continues until the store is empty. It then stays off until the store has filled again.

Top module: `bub_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `conv_req`, `tx_busy`, `tx_done`, `fifo_full` and `overflow` are 0, and `tx_line` and `fifo_empty` are 1.
- R2: Each request on `conv_req` is high for exactly one cycle. No further request is issued until `adc_valid` has delivered the result. Every accepted result is transmitted exactly once.
- R3: `conv_req` is never high while `fifo_full` is high. Requests resume once a read has dropped `fifo_full`.
- R4: `fifo_full` rises when DEPTH accepted words are held. `fifo_empty` is high exactly when no word is held. The two are never high together.
- R5: Draining begins only once the store has been full. It then goes on while words remain. After the store empties, no frame starts until the store has filled again.
- R6: The line is high whenever no frame is being sent. A frame is start bit 0, then WORD_W data bits least significant first, then stop bit 1. Each bit lasts OVS times (CLK_HZ / (BAUD*OVS)) clocks.
- R7: Words leave the serial line in the order their results were accepted.
- R8: `tx_busy` is high for the whole frame. `tx_done` is a one-cycle pulse in the cycle right after the stop bit ends, and `tx_busy` is low in that same cycle.
- R9: A result that arrives while `fifo_full` is high is discarded and never transmitted. `overflow` is high for the following cycle.
- R10: While `start_en` is low, no new request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | Allows conversion requests |
| adc_data | input | 16 | Converter result |
| adc_valid | input | 1 | One-cycle strobe qualifying `adc_data` |
| conv_req | output | 1 | One-cycle conversion request |
| tx_line | output | 1 | Serial transmit line, idle high |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle end-of-frame pulse |
| fifo_full | output | 1 | Store holds DEPTH words |
| fifo_empty | output | 1 | Store holds no word |
| overflow | output | 1 | A result was dropped in the previous cycle |

## Verification
Results are due at fixed distances from their causes. A request shows one cycle after the sequencer is free. A stored result changes the flags at the same edge that samples the strobe. `overflow` follows one cycle after a discarded result. `tx_done` comes exactly eighteen bit periods after the start bit first appears. The bench samples on the falling clock edge. It decodes each frame from the first low sample, reading at mid-bit, which is half a bit period plus whole bit periods later, and checks `tx_done` at the eighteen-period mark and one cycle after it. Its converter model counts its own responses at the moment it drives the strobe, so they are already settled when the full flag is read.

// File: rtl/bub_pkg.sv
package bub_pkg;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = WORD_W + 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic {SQ_ISSUE, SQ_WAIT} sq_state_e;
    typedef enum logic [1:0] {DR_IDLE, DR_LOAD, DR_SEND} dr_state_e;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

    // stop bit at the top, start bit at the bottom; shifted out LSB first
    function automatic frame_t make_frame(word_t w);
        return {1'b1, w, 1'b0};
    endfunction

    function automatic int tick_div(int clk_hz, int baud, int ovs);
        int d;
        d = clk_hz / (baud * ovs);
        return (d < 1) ? 1 : d;
    endfunction
endpackage

// File: rtl/bub_fifo.sv
module bub_fifo
    import bub_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_req,
    input  word_t       wr_data,
    input  logic        rd_req,
    output word_t       rd_data,
    output fifo_flags_t flags,
    output logic        overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    word_t          mem [DEPTH];
    logic [AW-1:0]  wptr, rptr;
    logic [CW-1:0]  count;
    logic           wr_ok, rd_ok;

    assign flags.full  = (count == CW'(DEPTH));
    assign flags.empty = (count == '0);
    assign wr_ok = wr_req && !flags.full;
    assign rd_ok = rd_req && !flags.empty;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            rd_data  <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= wr_req && flags.full;
            if (wr_ok) wptr <= bump(wptr);
            if (rd_ok) begin
                rptr    <= bump(rptr);
                rd_data <= mem[rptr];
            end
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/bub_uart_tx.sv
module bub_uart_tx
    import bub_pkg::*;
#(
    parameter int TICK_DIV = 651,
    parameter int OVS      = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t data,
    output logic  line,
    output logic  busy,
    output logic  done
);
    localparam int DW = $clog2(TICK_DIV + 1);
    localparam int SW = $clog2(OVS + 1);
    localparam int BW = $clog2(FRAME_W + 1);

    frame_t        sreg;
    logic [DW-1:0] div;
    logic [SW-1:0] sub;
    logic [BW-1:0] bitn;

    assign line = busy ? sreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            sreg <= '1;
            div  <= '0;
            sub  <= '0;
            bitn <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sreg <= make_frame(data);
                    div  <= '0;
                    sub  <= '0;
                    bitn <= '0;
                end
            end else if (div == DW'(TICK_DIV - 1)) begin
                div <= '0;
                if (sub == SW'(OVS - 1)) begin
                    sub  <= '0;
                    sreg <= {1'b1, sreg[FRAME_W-1:1]};
                    if (bitn == BW'(FRAME_W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bub_seq.sv
module bub_seq
    import bub_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_en,
    input  fifo_flags_t flags,
    input  logic        adc_valid,
    input  logic        tx_done,
    output logic        conv_req,
    output logic        rd_req,
    output logic        tx_start
);
    sq_state_e sq;
    dr_state_e dr;
    logic      drain_on;

    assign rd_req   = (dr == DR_IDLE) && (drain_on || flags.full) && !flags.empty;
    assign tx_start = (dr == DR_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            sq       <= SQ_ISSUE;
            conv_req <= 1'b0;
        end else begin
            conv_req <= 1'b0;
            case (sq)
                SQ_ISSUE: if (start_en && !flags.full) begin
                    conv_req <= 1'b1;
                    sq       <= SQ_WAIT;
                end
                SQ_WAIT: if (adc_valid) sq <= SQ_ISSUE;
                default: sq <= SQ_ISSUE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dr       <= DR_IDLE;
            drain_on <= 1'b0;
        end else begin
            if (flags.full)       drain_on <= 1'b1;
            else if (flags.empty) drain_on <= 1'b0;
            case (dr)
                DR_IDLE: if (rd_req)  dr <= DR_LOAD;
                DR_LOAD:              dr <= DR_SEND;
                DR_SEND: if (tx_done) dr <= DR_IDLE;
                default:              dr <= DR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bub_top.sv
module bub_top
    import bub_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600,
    parameter int OVS    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_en,
    input  logic [WORD_W-1:0] adc_data,
    input  logic              adc_valid,
    output logic              conv_req,
    output logic              tx_line,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              overflow
);
    localparam int TICK_DIV = tick_div(CLK_HZ, BAUD, OVS);

    fifo_flags_t flags;
    word_t       rd_data;
    logic        rd_req, tx_start;

    assign fifo_full  = flags.full;
    assign fifo_empty = flags.empty;

    bub_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_req(adc_valid), .wr_data(adc_data),
        .rd_req(rd_req), .rd_data(rd_data),
        .flags(flags), .overflow(overflow)
    );

    bub_seq u_seq (
        .clk(clk), .rst(rst), .start_en(start_en), .flags(flags),
        .adc_valid(adc_valid), .tx_done(tx_done),
        .conv_req(conv_req), .rd_req(rd_req), .tx_start(tx_start)
    );

    bub_uart_tx #(.TICK_DIV(TICK_DIV), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .data(rd_data),
        .line(tx_line), .busy(tx_busy), .done(tx_done)
    );
endmodule

// File: rtl/bub_chk.sv
module bub_chk (
    input logic clk,
    input logic rst,
    input logic adc_valid,
    input logic conv_req,
    input logic tx_line,
    input logic tx_busy,
    input logic tx_done,
    input logic fifo_full,
    input logic fifo_empty,
    input logic overflow
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) conv_req |=> !conv_req); // R2
    AST_NO_REQ_FULL: assert property (@(posedge clk) disable iff (rst) conv_req |-> !fifo_full); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(fifo_full && fifo_empty)); // R4
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !tx_busy |-> tx_line); // R6
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst) $rose(tx_busy) |-> !tx_line); // R6
    AST_DONE_END: assert property (@(posedge clk) disable iff (rst) tx_done |-> (!tx_busy && $past(tx_busy))); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst) overflow |-> $past(fifo_full && adc_valid)); // R9
endmodule

bind bub_top bub_chk u_chk (
    .clk(clk), .rst(rst), .adc_valid(adc_valid), .conv_req(conv_req),
    .tx_line(tx_line), .tx_busy(tx_busy), .tx_done(tx_done),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow)
);

// File: tb/sim_bub_top.sv
module sim_bub_top;
    localparam int DEPTH  = 4;
    localparam int OVS    = 8;
    localparam int BAUD   = 9600;
    localparam int CLK_HZ = BAUD * OVS * 2;
    localparam int BITC   = OVS * 2;
    localparam int N      = 12;
    localparam logic [15:0] VEC [N] = '{
        16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h8001, 16'h1234,
        16'h7FFE, 16'h0F0F, 16'hC3A5, 16'h0001, 16'h8000, 16'hBEEF
    };

    logic        clk = 0, rst = 1;
    logic        start_main = 0;
    logic [15:0] adc_data = '0;
    logic        adc_valid = 0;
    logic        start_en;
    logic        conv_req, tx_line, tx_busy, tx_done, fifo_full, fifo_empty, overflow;

    int k = 0, resp = 0, lim = 0;
    int n_chk = 0, n_fail = 0;
    int rx_n = 0;
    logic [15:0] rx [32];
    bit inj_req = 0, inj_done = 0, ovf_seen = 0;
    int r2_viol = 0, r3_viol = 0;

    assign start_en = start_main && (k < lim);

    always #5 clk = ~clk;

    bub_top #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u0 (
        .clk(clk), .rst(rst), .start_en(start_en), .adc_data(adc_data),
        .adc_valid(adc_valid), .conv_req(conv_req), .tx_line(tx_line),
        .tx_busy(tx_busy), .tx_done(tx_done), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] val_of(int idx);
        return (idx < N) ? VEC[idx] : 16'hA000 + 16'(idx);
    endfunction

    // converter model: answers each request after a fixed latency
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && conv_req) begin
                repeat (2) @(negedge clk);
                adc_data  = val_of(k);
                adc_valid = 1;
                k++;
                resp++;
                @(negedge clk);
                adc_valid = 0;
            end else if (!rst && inj_req && !inj_done && fifo_full) begin
                adc_data  = 16'hDEAD;
                adc_valid = 1;
                @(negedge clk);
                ovf_seen  = overflow;
                adc_valid = 0;
                inj_done  = 1;
            end
        end
    end

    // request rule monitor (R2, R3)
    initial begin
        bit prev = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (conv_req && prev) r2_viol++;
                if (conv_req && fifo_full) r3_viol++;
                prev = conv_req;
            end
        end
    end

    // serial frame decoder (R6, R8)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_line == 0) begin
                logic [15:0] w;
                repeat (BITC/2) @(negedge clk);
                chk(tx_line == 0, "R6 start bit", 32'(tx_line), 0);
                for (int b = 0; b < 16; b++) begin
                    repeat (BITC) @(negedge clk);
                    w[b] = tx_line;
                end
                repeat (BITC) @(negedge clk);
                chk(tx_line == 1, "R6 stop bit", 32'(tx_line), 1);
                repeat (BITC/2) @(negedge clk);
                chk(tx_done == 1 && tx_busy == 0, "R8 done pulse", {tx_done, tx_busy}, 2'b10);
                @(negedge clk);
                chk(tx_done == 0, "R8 done width", 32'(tx_done), 0);
                rx[rx_n] = w;
                rx_n++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d frames", rx_n, N + 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int early, base, reqs_before, stray;
        repeat (4) @(negedge clk);
        // R1 during reset and first cycle after
        chk(conv_req == 0 && tx_busy == 0 && tx_done == 0, "R1 ctl", {conv_req, tx_busy, tx_done}, 0);
        chk(tx_line == 1, "R1 line", 32'(tx_line), 1);
        chk(fifo_empty == 1 && fifo_full == 0 && overflow == 0, "R1 flags",
            {fifo_empty, fifo_full, overflow}, 3'b100);
        rst = 0;
        @(negedge clk);
        chk(conv_req == 0 && fifo_empty == 1 && tx_line == 1, "R1 post", {conv_req, fifo_empty, tx_line}, 3'b011);

        // R10: start_en low, nothing happens
        repeat (20) @(negedge clk);
        chk(k == 0, "R10 idle no request", k, 0);

        // phase 1: fill, then drain while refilling
        lim = N;
        start_main = 1;
        early = 0;
        while (!fifo_full) begin
            @(negedge clk);
            if (tx_line !== 1'b1) early++;
        end
        chk(early == 0, "R5 no frame before full", early, 0);
        chk(resp == DEPTH, "R4 full at depth", resp, DEPTH);
        chk(fifo_empty == 0, "R4 not empty when full", 32'(fifo_empty), 0);

        inj_req = 1;
        wait (inj_done);
        chk(ovf_seen == 1, "R9 overflow pulse", 32'(ovf_seen), 1);

        wait (rx_n == N);
        reqs_before = k;
        stray = 0;
        repeat (400) begin
            @(negedge clk);
            if (tx_line !== 1'b1 || conv_req) stray++;
        end
        chk(stray == 0, "R5 silent after empty", stray, 0);
        chk(rx_n == N, "R2 one frame per word", rx_n, N);
        chk(k == N && reqs_before == N, "R10 no request when disabled", k, N);
        chk(fifo_empty == 1 && fifo_full == 0, "R4 empty after drain", {fifo_empty, fifo_full}, 2'b10);
        for (int i = 0; i < N; i++)
            chk(rx[i] == VEC[i], "R7 order", rx[i], VEC[i]);

        // phase 2: refill before any frame, then resume after a read
        base = resp;
        early = 0;
        lim = 1000;
        while (!fifo_full) begin
            @(negedge clk);
            if (tx_line !== 1'b1) early++;
        end
        chk(early == 0, "R5 refill before drain", early, 0);
        chk(resp - base == DEPTH, "R4 refill count", resp - base, DEPTH);
        wait (rx_n == N + 1);
        chk(rx[N] == val_of(N), "R7 phase2 first word", rx[N], val_of(N));
        chk(k > N + DEPTH, "R3 resume after read", k, N + DEPTH + 1);
        chk(r2_viol == 0, "R2 single-cycle request", r2_viol, 0);
        chk(r3_viol == 0, "R3 no request while full", r3_viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule